// File: doc/BRIEF.md
# Streaming Fixed-Point FIR Decimator

This block is a finite impulse response filter for a stream of signed fixed-point samples. Each sample accepted on the input handshake goes into the newest slot of a delay line, and every older sample moves one slot deeper. All slots are multiplied by their coefficients in parallel. Each product is scaled down on its own, rounding toward zero, before the products are added. The sum is then clamped to the output width, and only every DECIM-th result is presented on the output handshake.

The coefficients are a packed parameter vector, so each instance is tuned at elaboration time. The default build has 20 taps, signed 16-bit samples, and 16-bit coefficients in a format with one sign bit and fifteen fraction bits. The accumulator is wide enough that no internal sum can wrap.

Top module: `fir_decim`

## Requirements
- R1: A synchronous reset clears every delay-line slot to zero, clears the decimation phase and drops out_valid. Until new samples displace the zeros, they contribute nothing to later outputs.
- R2: For accepted samples x[n], x[n-1], ..., the filtered value is the sum over tap k of the scaled product of coeff k and x[n-k]. Sample x[n] sits in tap 0.
- R3: Each tap product is shifted right by SCALE_SHIFT on its own, before it joins the sum. The remainders of separate taps never combine.
- R4: The per-tap scaling truncates toward zero. A negative product p becomes (p + 2^SCALE_SHIFT - 1) shifted arithmetically, so -1.5 scales to -1 and not -2.
- R5: A sum above 2^(OUT_W-1)-1 is presented as 2^(OUT_W-1)-1.
- R6: A sum below -2^(OUT_W-1) is presented as -2^(OUT_W-1).
- R7: Exactly one result is emitted for every DECIM accepted samples. It is emitted on the DECIM-th, 2*DECIM-th, ... accepted sample, counted from reset, and no result is emitted on the samples in between.
- R8: While out_valid is high and out_ready is low, out_data and out_valid hold and in_ready is low. A sample offered during that time is taken only once in_ready rises, so no sample is lost.
- R9: An emitted result appears on out_valid/out_data in the cycle right after the clock edge that accepted the DECIM-th sample. It includes that sample.
- R10: Coefficient k is the signed field COEFFS[k*COEFF_W +: COEFF_W]. Coefficient 0 weights the newest sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Filtered result available |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | OUT_W | Signed, saturated filtered result |

## Verification
The clocked assertions assume that the consumer obeys the handshake and that reset is asserted at time zero for at least one edge. The per-tap and saturation checks assume nothing about the input values. The bench raises reset from the first instant. It changes in_valid, in_data and out_ready only at falling edges. It keeps an offered sample stable until it is accepted, so every transfer it counts matches one the block sees.

// File: rtl/fir_decim_pkg.sv
package fir_decim_pkg;

    // Width of a counter that must hold values 0 .. n-1, never below one bit.
    function automatic int unsigned phase_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Accumulator width that cannot overflow when summing `terms` values of `w` bits.
    function automatic int unsigned sum_width(input int unsigned w, input int unsigned terms);
        return w + $clog2(terms) + 1;
    endfunction

endpackage

// File: rtl/fir_tap_scale.sv
module fir_tap_scale #(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned COEFF_W     = 16,
    parameter int unsigned SCALE_SHIFT = 15,
    localparam int unsigned PROD_W     = DATA_W + COEFF_W
) (
    input  logic signed [DATA_W-1:0]  sample,
    input  logic signed [COEFF_W-1:0] coef,
    output logic signed [PROD_W-1:0]  scaled
);

    localparam logic signed [PROD_W-1:0] BIAS = (PROD_W'(1) <<< SCALE_SHIFT) - PROD_W'(1);

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] biased;

    always_comb begin
        prod   = PROD_W'(sample) * PROD_W'(coef);
        biased = prod[PROD_W-1] ? (prod + BIAS) : prod;
        scaled = biased >>> SCALE_SHIFT;
    end

    // R4: scaling never moves a product across zero (truncation toward zero)
    always_comb begin
        a_trunc_dir_r4: assert (prod[PROD_W-1] ? !(scaled > 0) : !scaled[PROD_W-1])
            else $error("tap scaling crossed zero");
    end

endmodule

// File: rtl/fir_sum_sat.sv
module fir_sum_sat
    import fir_decim_pkg::*;
#(
    parameter int unsigned TERMS  = 20,
    parameter int unsigned TERM_W = 32,
    parameter int unsigned OUT_W  = 16,
    localparam int unsigned ACC_W = sum_width(TERM_W, TERMS)
) (
    input  logic [TERMS-1:0][TERM_W-1:0] terms,
    output logic signed [OUT_W-1:0]      result
);

    localparam logic signed [ACC_W-1:0] OMAX = (ACC_W'(1) <<< (OUT_W - 1)) - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] OMIN = -(ACC_W'(1) <<< (OUT_W - 1));

    logic signed [ACC_W-1:0] acc;

    always_comb begin
        acc = '0;
        for (int k = 0; k < int'(TERMS); k++) begin
            acc = acc + ACC_W'($signed(terms[k]));
        end
        if (acc > OMAX) begin
            result = OMAX[OUT_W-1:0];
        end else if (acc < OMIN) begin
            result = OMIN[OUT_W-1:0];
        end else begin
            result = acc[OUT_W-1:0];
        end
    end

    // R5/R6: clamping keeps the sign of the full-width sum
    always_comb begin
        a_sat_sign_r6: assert ((acc < 0) == result[OUT_W-1])
            else $error("saturated result changed sign");
    end

endmodule

// File: rtl/fir_decim.sv
module fir_decim
    import fir_decim_pkg::*;
#(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned COEFF_W     = 16,
    parameter int unsigned OUT_W       = 16,
    parameter int unsigned TAPS        = 20,
    parameter int unsigned DECIM       = 1,
    parameter int unsigned SCALE_SHIFT = 15,
    parameter logic [TAPS*COEFF_W-1:0] COEFFS = {TAPS{COEFF_W'(1638)}}
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic signed [OUT_W-1:0]  out_data
);

    localparam int unsigned PROD_W = DATA_W + COEFF_W;
    localparam int unsigned CNT_W  = phase_width(DECIM);
    localparam logic [CNT_W-1:0] LAST_PHASE = CNT_W'(DECIM - 1);

    typedef struct packed {
        logic [TAPS-1:0][DATA_W-1:0] taps;
        logic [CNT_W-1:0]            phase;
        logic                        vld;
        logic [OUT_W-1:0]            dat;
    } state_t;

    state_t st_d, st_q;

    logic [TAPS-1:0][DATA_W-1:0] taps_next;
    logic [TAPS-1:0][PROD_W-1:0] scaled;
    logic signed [OUT_W-1:0]     filt;
    logic                        accept;

    // Delay line as it will be once the offered sample is taken: tap 0 newest.
    assign taps_next = {st_q.taps[TAPS-2:0], in_data};

    generate
        for (genvar k = 0; k < int'(TAPS); k++) begin : g_tap
            logic signed [PROD_W-1:0] tap_out;
            fir_tap_scale #(
                .DATA_W     (DATA_W),
                .COEFF_W    (COEFF_W),
                .SCALE_SHIFT(SCALE_SHIFT)
            ) i_tap (
                .sample(taps_next[k]),
                .coef  (COEFFS[k*COEFF_W +: COEFF_W]),
                .scaled(tap_out)
            );
            assign scaled[k] = tap_out;
        end
    endgenerate

    fir_sum_sat #(
        .TERMS (TAPS),
        .TERM_W(PROD_W),
        .OUT_W (OUT_W)
    ) i_sum (
        .terms (scaled),
        .result(filt)
    );

    assign in_ready = !st_q.vld || out_ready;
    assign accept   = in_valid && in_ready;

    always_comb begin
        st_d = st_q;
        if (out_ready) begin
            st_d.vld = 1'b0;
        end
        if (accept) begin
            st_d.taps = taps_next;
            if (st_q.phase == LAST_PHASE) begin
                st_d.phase = '0;
                st_d.vld   = 1'b1;
                st_d.dat   = filt;
            end else begin
                st_d.phase = st_q.phase + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.dat;

    // ---------------- assertions ----------------
    int unsigned n_in_q, n_out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            n_in_q  <= 0;
            n_out_q <= 0;
        end else begin
            if (in_valid && in_ready) n_in_q <= n_in_q + 1;
            if (out_valid && out_ready) n_out_q <= n_out_q + 1;
        end
    end

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)))
        else $error("output changed under backpressure");

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid)
        else $error("output valid right after reset");

    p_rate_r7: assert property (@(posedge clk) disable iff (rst)
        (n_out_q * DECIM) <= n_in_q)
        else $error("more results than input samples allow");

endmodule

// File: tb/test_fir_decim.sv
`timescale 1ns/1ps
module test_fir_decim;

    localparam int NT = 4;
    localparam int DEC = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_ready;
    logic signed [15:0] in_data = '0;
    logic out_valid;
    logic out_ready = 1'b1;
    logic signed [15:0] out_data;

    // tap3 = 32767, tap2 = 8192, tap1 = -16384, tap0 = 16384
    fir_decim #(
        .DATA_W(16), .COEFF_W(16), .OUT_W(16), .TAPS(NT), .DECIM(DEC),
        .SCALE_SHIFT(15), .COEFFS(64'h7FFF_2000_C000_4000)
    ) i_fir_decim (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int hist [NT];
    int acc_cnt = 0;
    int coef [NT] = '{16384, -16384, 8192, 32767};

    function automatic int model();
        longint s = 0;
        for (int k = 0; k < NT; k++) begin
            longint p = longint'(hist[k]) * longint'(coef[k]);
            if (p < 0) p = p + 32767;
            s += (p >>> 15);
        end
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        return int'(s);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < NT; k++) hist[k] = 0;
        acc_cnt = 0;
    endtask

    task automatic shift_in(input int x);
        for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = x;
        acc_cnt++;
    endtask

    // Offer one sample, wait for acceptance, then check the output one cycle later (R9).
    task automatic push(input int x, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_data = 16'(x);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        shift_in(x);
        @(negedge clk);
        in_valid = 1'b0;
        if (acc_cnt % DEC == 0) begin
            check(out_valid == 1'b1, {tag, " R7 emit"}, int'(out_valid), 1);
            check(int'(out_data) == model(), {tag, " R9 value"}, int'(out_data), model());
        end else begin
            check(out_valid == 1'b0, {tag, " R7 no emit"}, int'(out_valid), 0);
        end
    endtask

    task automatic t_reset();
        do_reset();
        check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    endtask

    task automatic t_impulse();
        do_reset();
        push(1000, "R10 impulse a");
        push(0, "R10 impulse b");
        check(int'(out_data) == -500, "R10 tap1 weight", int'(out_data), -500);
        push(0, "R2 impulse c");
        push(0, "R2 impulse d");
        check(int'(out_data) == 999, "R10 tap3 weight", int'(out_data), 999);
    endtask

    task automatic t_trunc();
        do_reset();
        push(1, "R3 half a");
        push(1, "R3 half b");
        check(int'(out_data) == 0, "R3 per-tap truncation", int'(out_data), 0);
        do_reset();
        push(-3, "R4 neg a");
        push(3, "R4 neg b");
        check(int'(out_data) == 2, "R4 toward zero", int'(out_data), 2);
        push(5, "R2 mix a");
        push(-7, "R2 mix b");
        push(11, "R2 mix c");
        push(-13, "R2 mix d");
    endtask

    task automatic t_sat();
        do_reset();
        for (int i = 0; i < 4; i++) push(32767, "R5 high");
        check(int'(out_data) == 32767, "R5 clamp high", int'(out_data), 32767);
        for (int i = 0; i < 4; i++) push(-32768, "R6 low");
        check(int'(out_data) == -32768, "R6 clamp low", int'(out_data), -32768);
    endtask

    task automatic t_backpressure();
        int held;
        do_reset();
        out_ready = 1'b0;
        push(200, "R8 bp a");
        push(-400, "R8 bp b");
        held = int'(out_data);
        @(negedge clk);
        in_valid = 1'b1; in_data = 16'(3000);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(in_ready == 1'b0, "R8 in_ready low", int'(in_ready), 0);
            check(out_valid == 1'b1 && int'(out_data) == held, "R8 output held",
                  int'(out_data), held);
        end
        out_ready = 1'b1;
        @(posedge clk);
        shift_in(3000);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b0, "R8 drained", int'(out_valid), 0);
        push(-50, "R8 no loss");
    endtask

    initial begin
        t_reset();
        t_impulse();
        t_trunc();
        t_sat();
        t_backpressure();
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog R1-any actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule